// File: doc/BRIEF.md
# Modem Line Monitor and Control Register

This block sits beside a serial port and handles its four modem handshake inputs and four modem control outputs. The raw input pins are clear-to-send, data-set-ready, ring indicator and carrier detect, all treated as active high. Each passes through a two-flop synchroniser. The synchronised levels appear in a status byte. Change flags in the same byte stick until software reads it. Any set flag raises a modem interrupt event. A control byte drives the data-terminal-ready and request-to-send pins and two auxiliary outputs, and it holds a loopback switch. In loopback, the control bits feed the status inputs internally and the external outputs are held low.

A one-bit register select picks the register. Value 0 selects the control byte and value 1 selects the status byte. `rd_data` always shows the selected register. Reading the status byte with `rd_en` clears its change flags at that clock edge.

A two-state machine keeps the change detector from raising false flags. State `ST_SETTLE` holds the edge detector disarmed while the synchroniser refills. State `ST_WATCH` arms it. Transition `RESET_ENTRY` enters `ST_SETTLE` on reset. Transition `SETTLE_DONE` moves from `ST_SETTLE` to `ST_WATCH` after `SYNC_STAGES+1` cycles. Transition `SOURCE_SWAP` returns to `ST_SETTLE` from either state when a control write changes the loopback bit, and it restarts the count.

Top module: `modem_line_monitor`

## Requirements
- R1: Status bits 4, 5, 6 and 7 hold the synchronised levels of CTS, DSR, RI and CD. A pin change shows in these bits after the second rising edge that follows it.
- R2: Status bit 0 (CTS), bit 1 (DSR) and bit 3 (CD) set on a change of the line in either direction. Each sets at the third rising edge after the pin change.
- R3: Status bit 2 sets only when RI falls from 1 to 0. A rising RI sets no flag.
- R4: Change flags stay set until the status byte is read. The read returns the flags still set, and all four flags clear at that clock edge.
- R5: A change detected at the same edge as a status read leaves its own flag set. The read still clears the other flags.
- R6: `irq_event` is high exactly when at least one change flag is set.
- R7: A write with select 0 stores bits 4:0 of the data: bit 0 DTR, bit 1 RTS, bit 2 AUX1, bit 3 AUX2, bit 4 loopback. A read of the control byte returns zero in bits 7:5. With loopback clear, the four output pins follow bits 3:0.
- R8: With loopback set, all four output pins are 0 and the external inputs are ignored. Internally DTR feeds DSR, RTS feeds CTS, AUX1 feeds RI and AUX2 feeds CD.
- R9: For `SYNC_STAGES+1` cycles after reset, and after any control write that flips the loopback bit, no change flag sets. The levels keep tracking during this time.
- R10: After reset the control byte, the change flags and the output pins are 0. Writes with select 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0 selects control byte, 1 selects status byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; clears flags when the status byte is selected |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Selected register contents |
| in_cts | input | 1 | Clear-to-send pin, asynchronous |
| in_dsr | input | 1 | Data-set-ready pin, asynchronous |
| in_ri | input | 1 | Ring indicator pin, asynchronous |
| in_cd | input | 1 | Carrier detect pin, asynchronous |
| out_dtr | output | 1 | Data-terminal-ready output |
| out_rts | output | 1 | Request-to-send output |
| out_aux1 | output | 1 | Auxiliary output 1 |
| out_aux2 | output | 1 | Auxiliary output 2 |
| irq_event | output | 1 | Modem-status interrupt event |

## Verification
A status read that clears the flags can land on the same edge as the setting of a new change flag. The bench first lets a DSR change set its flag. It then toggles CTS and holds the status read high for exactly the cycle before the edge where the CTS flag sets. The value read must show only the DSR flag. After that edge, the CTS flag must still be set and the DSR flag must be gone. A second pairing is also checked: a loopback switch happens while the synchronised source changes, and no flag may appear.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int LINE_COUNT = 4;
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_CD  = 3;

    localparam int CTRL_BITS = 5;
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_AUX1 = 2;
    localparam int CB_AUX2 = 3;
    localparam int CB_LOOP = 4;

    // lines whose flag reacts only to a falling level
    localparam logic [LINE_COUNT-1:0] FALL_ONLY = 4'b0100;

    typedef enum logic [0:0] {
        ST_SETTLE = 1'b0,
        ST_WATCH  = 1'b1
    } mon_state_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= d_async;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[g] <= '0;
            else        pipe[g] <= pipe[g-1];
        end
    end

    assign q_sync = pipe[STAGES-1];

    initial begin
        AST_SYNC_DEPTH: assert (STAGES >= 2) else $error("synchroniser too short"); // R1
    end
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
    parameter int                WIDTH     = 4,
    parameter logic [WIDTH-1:0]  FALL_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic             arm,
    input  logic             clr,
    output logic [WIDTH-1:0] flags
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] hit;

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        if (FALL_MASK[i]) begin : g_fall
            assign hit[i] = arm & prev_q[i] & ~level[i];
        end else begin : g_any
            assign hit[i] = arm & (prev_q[i] ^ level[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            flags  <= '0;
        end else begin
            prev_q <= level;
            flags  <= (flags & ~{WIDTH{clr}}) | hit;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && flags != '0) |=> ((flags & $past(flags)) == $past(flags))); // R4
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && hit == '0) |=> (flags == '0)); // R4
    AST_NO_FLAG_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm) |=> ((flags & ~$past(flags)) == '0)); // R9
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && hit != '0) |=> ((flags & $past(hit)) == $past(hit))); // R5
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg #(
    parameter int CW      = 5,
    parameter int LOOP_AT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] q,
    output logic          loop_flip
);
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (wr) q <= wdata;
    end

    assign loop_flip = wr && (wdata[LOOP_AT] != q[LOOP_AT]);

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr) |=> $stable(q)); // R10
endmodule

// File: rtl/modem_line_monitor.sv
module modem_line_monitor #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              in_cts,
    input  logic              in_dsr,
    input  logic              in_ri,
    input  logic              in_cd,
    output logic              out_dtr,
    output logic              out_rts,
    output logic              out_aux1,
    output logic              out_aux2,
    output logic              irq_event
);
    import mdm_pkg::*;

    localparam int SETTLE_LEN = SYNC_STAGES + 1;
    localparam int CNT_W      = $clog2(SETTLE_LEN + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_LEN - 1);

    logic [CTRL_BITS-1:0]  ctl_q;
    logic                  loop_flip;
    logic                  ctl_wr;
    logic [LINE_COUNT-1:0] line_src;
    logic [LINE_COUNT-1:0] line_lvl;
    logic [LINE_COUNT-1:0] line_flag;
    logic                  flag_clr;
    logic                  arm;
    logic                  loop_on;
    logic                  wdata_unused;

    mon_state_t            state_q, state_d;
    logic [CNT_W-1:0]      cnt_q, cnt_d;

    // ---------------- control register ----------------
    assign ctl_wr       = wr_en && !reg_sel;
    assign wdata_unused = ^wr_data[DATA_W-1:CTRL_BITS];

    mdm_ctrl_reg #(.CW(CTRL_BITS), .LOOP_AT(CB_LOOP)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (ctl_wr),
        .wdata     (wr_data[CTRL_BITS-1:0]),
        .q         (ctl_q),
        .loop_flip (loop_flip)
    );

    assign loop_on = ctl_q[CB_LOOP];

    // ---------------- source selection ----------------
    always_comb begin
        if (loop_on) begin
            line_src[LN_CTS] = ctl_q[CB_RTS];
            line_src[LN_DSR] = ctl_q[CB_DTR];
            line_src[LN_RI]  = ctl_q[CB_AUX1];
            line_src[LN_CD]  = ctl_q[CB_AUX2];
        end else begin
            line_src[LN_CTS] = in_cts;
            line_src[LN_DSR] = in_dsr;
            line_src[LN_RI]  = in_ri;
            line_src[LN_CD]  = in_cd;
        end
    end

    mdm_sync #(.WIDTH(LINE_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (line_src),
        .q_sync  (line_lvl)
    );

    // ---------------- settle / watch state machine ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE;          // RESET_ENTRY
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_SETTLE: begin
                if (loop_flip) begin
                    cnt_d = '0;            // SOURCE_SWAP (restart)
                end else if (cnt_q == SETTLE_LAST) begin
                    state_d = ST_WATCH;    // SETTLE_DONE
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_WATCH: begin
                if (loop_flip) begin
                    state_d = ST_SETTLE;   // SOURCE_SWAP
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_SETTLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        arm = 1'b0;
        unique case (state_q)
            ST_SETTLE: arm = 1'b0;
            ST_WATCH:  arm = 1'b1;
            default:   arm = 1'b0;
        endcase
    end

    // ---------------- change detection ----------------
    assign flag_clr = rd_en && reg_sel;

    mdm_delta #(.WIDTH(LINE_COUNT), .FALL_MASK(FALL_ONLY)) u_delta (
        .clk   (clk),
        .rst_n (rst_n),
        .level (line_lvl),
        .arm   (arm),
        .clr   (flag_clr),
        .flags (line_flag)
    );

    // ---------------- outputs ----------------
    always_comb begin
        rd_data = '0;
        if (reg_sel) rd_data[2*LINE_COUNT-1:0] = {line_lvl, line_flag};
        else         rd_data[CTRL_BITS-1:0]    = ctl_q;
    end

    assign out_dtr   = ctl_q[CB_DTR]  & ~loop_on;
    assign out_rts   = ctl_q[CB_RTS]  & ~loop_on;
    assign out_aux1  = ctl_q[CB_AUX1] & ~loop_on;
    assign out_aux2  = ctl_q[CB_AUX2] & ~loop_on;
    assign irq_event = |line_flag;

    AST_LOOP_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        loop_on |-> {out_dtr, out_rts, out_aux1, out_aux2} == 4'b0000); // R8
    AST_CTRL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> rd_data[DATA_W-1:CTRL_BITS] == '0); // R7
    AST_SETTLE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE) |-> (cnt_q < CNT_W'(SETTLE_LEN))); // R9
    AST_IRQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_event) |-> $past(arm)); // R6
    AST_SWAP_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        loop_flip |=> (state_q == ST_SETTLE && cnt_q == '0)); // R9
endmodule

// File: tb/tb_modem_line_monitor.sv
`timescale 1ns/1ps
module tb_modem_line_monitor;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_sel, wr_en, rd_en;
    logic [7:0] wr_data, rd_data;
    logic       in_cts, in_dsr, in_ri, in_cd;
    logic       out_dtr, out_rts, out_aux1, out_aux2, irq_event;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    modem_line_monitor dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
        .in_cts(in_cts), .in_dsr(in_dsr), .in_ri(in_ri), .in_cd(in_cd),
        .out_dtr(out_dtr), .out_rts(out_rts), .out_aux1(out_aux1),
        .out_aux2(out_aux2), .irq_event(irq_event)
    );

    // pins {cd,ri,dsr,cts} and the status byte expected 3 edges later
    localparam int NV = 12;
    localparam logic [11:0] VEC [NV] = '{
        {4'b0000, 8'h0F}, {4'b0001, 8'h11}, {4'b0011, 8'h32},
        {4'b0111, 8'h70}, {4'b0011, 8'h34}, {4'b1011, 8'hB8},
        {4'b1000, 8'h83}, {4'b0100, 8'h48}, {4'b0000, 8'h04},
        {4'b1111, 8'hFB}, {4'b0000, 8'h0F}, {4'b0000, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic set_pins(input logic [3:0] p);
        {in_cd, in_ri, in_dsr, in_cts} = p;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_ctrl(input logic [7:0] d);
        reg_sel = 1'b0; wr_en = 1'b1; wr_data = d;
        tick(1);
        wr_en = 1'b0; reg_sel = 1'b1;
    endtask

    task automatic read_clear();
        reg_sel = 1'b1; rd_en = 1'b1;
        tick(1);
        rd_en = 1'b0;
    endtask

    task automatic peek_ctrl(output logic [7:0] v);
        reg_sel = 1'b0; #1; v = rd_data; reg_sel = 1'b1; #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0; reg_sel = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        set_pins(4'b1111);
        tick(3);
        // R10 reset state
        check("R10 flags at reset", {4'h0, rd_data[3:0]}, 8'h00);
        check("R10 pins at reset", {4'h0, out_aux2, out_aux1, out_rts, out_dtr}, 8'h00);
        peek_ctrl(v);
        check("R10 ctrl at reset", v, 8'h00);
        rst_n = 1'b1;
        tick(6);
        // R9 settle after reset: levels high, no flags
        check("R9 settle after reset", rd_data, 8'hF0);
        check("R6 irq quiet after settle", {7'd0, irq_event}, 8'h00);

        // vector table: R1 R2 R3 R4 R6
        for (int i = 0; i < NV; i++) begin
            set_pins(VEC[i][11:8]);
            tick(3);
            check("R1/R2/R3 status vector", rd_data, VEC[i][7:0]);
            check("R6 irq vector", {7'd0, irq_event}, {7'd0, VEC[i][3:0] != 4'h0});
            read_clear();
            check("R4 clear after read", {4'h0, rd_data[3:0]}, 8'h00);
        end

        // R4 sticky over many cycles
        set_pins(4'b0001);
        tick(3);
        tick(20);
        check("R4 flag sticky", rd_data, 8'h11);
        read_clear();
        check("R4 cleared", rd_data, 8'h10);

        // R5 coincident read and new change
        set_pins(4'b0011);                 // DSR change
        tick(3);
        check("R5 preload", rd_data, 8'h32);
        set_pins(4'b0010);                 // CTS change
        tick(2);
        rd_en = 1'b1;
        check("R5 read value before clear", rd_data, 8'h22);
        tick(1);
        rd_en = 1'b0;
        check("R5 new flag survives read", rd_data, 8'h21);
        read_clear();
        set_pins(4'b0000);
        tick(3);
        read_clear();

        // R7 control register
        write_ctrl(8'h0F);
        peek_ctrl(v);
        check("R7 ctrl read", v, 8'h0F);
        check("R7 pins follow", {4'h0, out_aux2, out_aux1, out_rts, out_dtr}, 8'h0F);
        write_ctrl(8'hE5);
        peek_ctrl(v);
        check("R7 top bits zero", v, 8'h05);
        check("R7 pins pattern", {4'h0, out_aux2, out_aux1, out_rts, out_dtr}, 8'h05);

        // R10 status write ignored
        reg_sel = 1'b1; wr_en = 1'b1; wr_data = 8'hFF;
        tick(1);
        wr_en = 1'b0;
        peek_ctrl(v);
        check("R10 status write ignored ctrl", v, 8'h05);
        check("R10 status write ignored status", rd_data, 8'h00);

        // R8 loopback with R9 settle on swap
        write_ctrl(8'h13);
        check("R8 pins idle in loopback", {4'h0, out_aux2, out_aux1, out_rts, out_dtr}, 8'h00);
        tick(5);
        check("R9 swap raises no flag", rd_data, 8'h30);
        set_pins(4'b1111);
        tick(5);
        check("R8 external pins ignored", rd_data, 8'h30);
        write_ctrl(8'h1C);
        tick(3);
        check("R8 loop mapping change", rd_data, 8'hCB);
        read_clear();
        write_ctrl(8'h18);
        tick(3);
        check("R3 loop RI fall", rd_data, 8'h84);
        read_clear();
        write_ctrl(8'h00);
        tick(5);
        check("R9 leave loopback quiet", rd_data, 8'hF0);
        check("R6 irq after leave", {7'd0, irq_event}, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule